// File: doc/BRIEF.md
# Global Key Suppression Arbiter

This block decides, for one group of up to five touch keys, which single key may go active when several of them see a detection at once. Each channel supplies a signed strength (signal minus its reference), a flag saying a detection is confirmed and waiting to drive the output, and a flag saying the key is already active. The arbiter answers with a per-channel suppress line: a waiting key that loses the contest must not go active.

The contest is global. Every key is ranked against every other key of the instance, wherever it sits on the panel. A waiting key loses if any other key is already active, or if any other key shows a stronger signal. Negative strengths rank as zero. Equal strengths go to the lower channel number. When the active key lets go, a waiting key that is the strongest is released in the same cycle.

A second output marks each suppressed key whose strength is above the detection threshold. Drift tracking for that key is held while the mark is set. The whole path is combinational. An enable input turns the function off, and then nothing is suppressed.

Top module: `ksup_arbiter`

## Requirements
- R1: With `sup_en` low, every bit of `key_block` and `drift_hold` is 0, whatever the other inputs are.
- R2: With `sup_en` high, a channel whose `key_wait` bit is 1 and whose `key_on` bit is 0 gets `key_block` 1 if the `key_on` bit of any other channel is 1.
- R3: With `sup_en` high, a waiting, non-active channel gets `key_block` 1 if any other channel, at any channel number and whether waiting or not, has a strictly larger strength.
- R4: When two channels have equal strength, the lower channel number outranks the higher one. The higher waiting channel is blocked and the lower one is not.
- R5: Strength is channel i's field of `key_delta`, bits [16*i+15:16*i], read as two's complement. A negative value ranks as strength zero, so it ties with a zero value, down to -32768.
- R6: `drift_hold[i]` is 1 exactly when `key_block[i]` is 1 and channel i's signed delta is greater than the threshold (default 6). A delta equal to 6 gives 0 and a delta of 7 gives 1.
- R7: A channel whose `key_wait` bit is 0, or whose `key_on` bit is 1, never has `key_block` set.
- R8: The outputs are combinational. They reflect a change of inputs in the same cycle, with no clock edge needed.
- R9: When the active channel releases (its `key_on` bit goes to 0) and a waiting channel is then the strongest, that channel's `key_block` bit returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sup_en | input | 1 | 1 turns suppression on, 0 turns it off |
| key_delta | input | 80 | Five signed 16-bit strengths; channel i uses bits [16*i+15:16*i] |
| key_wait | input | 5 | Channel has a confirmed detection waiting to go active |
| key_on | input | 5 | Channel output is currently active |
| key_block | output | 5 | Channel's pending detection must not go active |
| drift_hold | output | 5 | Blocked channel above threshold; hold its drift tracking |

## Verification
The bench targets the tie cases. Two equal waiting keys must block only the higher number. A negative delta, including the most negative value, must tie with zero rather than wrap to a huge strength. A design that took the sign bit as magnitude would block the wrong key. The bench also blocks a key through a stronger key that is not waiting and sits far away, which catches a design that compares only neighbours or only waiting keys. The threshold edge at 6 and 7 catches an off-by-one in the drift-hold compare. A release check catches a block that stays set after the active key lets go, or a block that applies to the active key itself.

// File: rtl/ksup_pkg.sv
package ksup_pkg;
  localparam int unsigned DEF_NUM_KEYS = 5;
  localparam int unsigned DEF_DELTA_W  = 16;
  localparam int          DEF_THRESH   = 6;
endpackage

// File: rtl/ksup_strength.sv
module ksup_strength #(
  parameter int unsigned DELTA_W = ksup_pkg::DEF_DELTA_W,
  parameter int          THRESH  = ksup_pkg::DEF_THRESH
) (
  input  logic signed [DELTA_W-1:0] delta,
  output logic        [DELTA_W-2:0] mag,
  output logic                      above
);
  localparam logic signed [DELTA_W-1:0] THR = DELTA_W'(THRESH);

  // negative deltas rank as zero strength
  always_comb begin
    mag   = delta[DELTA_W-1] ? '0 : delta[DELTA_W-2:0];
    above = (delta > THR);
  end
endmodule

// File: rtl/ksup_rank.sv
module ksup_rank #(
  parameter int unsigned NUM_KEYS = ksup_pkg::DEF_NUM_KEYS,
  parameter int unsigned MAG_W    = ksup_pkg::DEF_DELTA_W - 1
) (
  input  logic [NUM_KEYS*MAG_W-1:0] mag_flat,
  output logic [NUM_KEYS-1:0]       outranked
);
  logic [MAG_W-1:0] mag [NUM_KEYS];

  genvar g;
  generate
    for (g = 0; g < NUM_KEYS; g++) begin : g_unpack
      assign mag[g] = mag_flat[g*MAG_W +: MAG_W];
    end
  endgenerate

  // a key is outranked by any stronger key, or an equal key of lower index
  always_comb begin
    for (int i = 0; i < NUM_KEYS; i++) begin
      outranked[i] = 1'b0;
      for (int j = 0; j < NUM_KEYS; j++) begin
        if (j != i) begin
          if ((mag[j] > mag[i]) || ((mag[j] == mag[i]) && (j < i)))
            outranked[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ksup_gate.sv
module ksup_gate #(
  parameter int unsigned NUM_KEYS = ksup_pkg::DEF_NUM_KEYS
) (
  input  logic                sup_en,
  input  logic [NUM_KEYS-1:0] key_wait,
  input  logic [NUM_KEYS-1:0] key_on,
  input  logic [NUM_KEYS-1:0] outranked,
  input  logic [NUM_KEYS-1:0] above,
  output logic [NUM_KEYS-1:0] key_block,
  output logic [NUM_KEYS-1:0] drift_hold
);
  logic [NUM_KEYS-1:0] other_on;

  always_comb begin
    for (int i = 0; i < NUM_KEYS; i++) begin
      other_on[i] = 1'b0;
      for (int j = 0; j < NUM_KEYS; j++) begin
        if (j != i) other_on[i] = other_on[i] | key_on[j];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_KEYS; i++) begin
      key_block[i]  = sup_en & key_wait[i] & ~key_on[i] & (other_on[i] | outranked[i]);
      drift_hold[i] = key_block[i] & above[i];
    end
  end
endmodule

// File: rtl/ksup_arbiter.sv
module ksup_arbiter #(
  parameter int unsigned NUM_KEYS = ksup_pkg::DEF_NUM_KEYS,
  parameter int unsigned DELTA_W  = ksup_pkg::DEF_DELTA_W,
  parameter int          THRESH   = ksup_pkg::DEF_THRESH
) (
  input  logic                        sup_en,
  input  logic [NUM_KEYS*DELTA_W-1:0] key_delta,
  input  logic [NUM_KEYS-1:0]         key_wait,
  input  logic [NUM_KEYS-1:0]         key_on,
  output logic [NUM_KEYS-1:0]         key_block,
  output logic [NUM_KEYS-1:0]         drift_hold
);
  localparam int unsigned MAG_W = DELTA_W - 1;

  logic [NUM_KEYS*MAG_W-1:0] mag_flat;
  logic [NUM_KEYS-1:0]       above;
  logic [NUM_KEYS-1:0]       outranked;

  genvar g;
  generate
    for (g = 0; g < NUM_KEYS; g++) begin : g_chan
      ksup_strength #(.DELTA_W(DELTA_W), .THRESH(THRESH)) u_str (
        .delta (key_delta[g*DELTA_W +: DELTA_W]),
        .mag   (mag_flat[g*MAG_W +: MAG_W]),
        .above (above[g])
      );
    end
  endgenerate

  ksup_rank #(.NUM_KEYS(NUM_KEYS), .MAG_W(MAG_W)) u_rank (
    .mag_flat  (mag_flat),
    .outranked (outranked)
  );

  ksup_gate #(.NUM_KEYS(NUM_KEYS)) u_gate (
    .sup_en     (sup_en),
    .key_wait   (key_wait),
    .key_on     (key_on),
    .outranked  (outranked),
    .above      (above),
    .key_block  (key_block),
    .drift_hold (drift_hold)
  );
endmodule

// File: rtl/ksup_arbiter_chk.sv
module ksup_arbiter_chk #(
  parameter int unsigned NUM_KEYS = ksup_pkg::DEF_NUM_KEYS
) (
  input logic                sup_en,
  input logic [NUM_KEYS-1:0] key_wait,
  input logic [NUM_KEYS-1:0] key_on,
  input logic [NUM_KEYS-1:0] key_block,
  input logic [NUM_KEYS-1:0] drift_hold
);
  always_comb begin
    if (!$isunknown({sup_en, key_wait, key_on, key_block, drift_hold})) begin
      // R1
      off_quiet_chk: assert (sup_en || (key_block == '0 && drift_hold == '0));
      // R7
      block_only_waiting_chk: assert ((key_block & ~(key_wait & ~key_on)) == '0);
      // R6
      hold_needs_block_chk: assert ((drift_hold & ~key_block) == '0);
      // R3
      single_winner_chk: assert (!sup_en || $countones(key_wait & ~key_on & ~key_block) <= 1);
      for (int i = 0; i < NUM_KEYS; i++) begin
        // R2
        other_on_blocks_chk: assert (!(sup_en && key_wait[i] && !key_on[i] &&
                                      ((key_on & ~(NUM_KEYS'(1) << i)) != '0)) || key_block[i]);
      end
    end
  end
endmodule

bind ksup_arbiter ksup_arbiter_chk #(.NUM_KEYS(NUM_KEYS)) u_chk (
  .sup_en     (sup_en),
  .key_wait   (key_wait),
  .key_on     (key_on),
  .key_block  (key_block),
  .drift_hold (drift_hold)
);

// File: tb/tb_ksup_arbiter.sv
module tb_ksup_arbiter;
  logic        clk;
  logic        rst_n;
  logic        sup_en;
  logic [79:0] key_delta;
  logic [4:0]  key_wait;
  logic [4:0]  key_on;
  logic [4:0]  key_block;
  logic [4:0]  drift_hold;
  int          checks;
  int          errors;

  ksup_arbiter dut (
    .sup_en     (sup_en),
    .key_delta  (key_delta),
    .key_wait   (key_wait),
    .key_on     (key_on),
    .key_block  (key_block),
    .drift_hold (drift_hold)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic set_d(input int ch, input int val);
    key_delta[ch*16 +: 16] = val[15:0];
  endtask

  task automatic clear_in();
    key_delta = '0; key_wait = '0; key_on = '0;
  endtask

  task automatic check(input string req, input logic [4:0] eb, input logic [4:0] eh);
    checks++;
    if (key_block !== eb || drift_hold !== eh) begin
      errors++;
      $display("FAIL %s block=%b hold=%b expected block=%b hold=%b",
               req, key_block, drift_hold, eb, eh);
    end
  endtask

  task automatic t_idle();
    @(negedge clk); sup_en = 1'b1; clear_in(); #1;
    check("R7 idle", 5'b00000, 5'b00000);
  endtask

  task automatic t_disabled();
    @(negedge clk); clear_in(); sup_en = 1'b0;
    set_d(1, 10); set_d(2, 20); key_wait = 5'b00110; key_on = 5'b10000; #1;
    check("R1 disabled", 5'b00000, 5'b00000);
  endtask

  task automatic t_other_active();
    @(negedge clk); clear_in(); sup_en = 1'b1;
    set_d(0, 5); set_d(3, 50); key_on = 5'b00001; key_wait = 5'b01001; #1;
    check("R2 R7 other active", 5'b01000, 5'b01000);
  endtask

  task automatic t_stronger();
    @(negedge clk); clear_in(); sup_en = 1'b1;
    set_d(0, 10); set_d(4, 30); key_wait = 5'b10001; #1;
    check("R3 far stronger key", 5'b00001, 5'b00001);
    @(negedge clk); clear_in();
    set_d(1, 8); set_d(2, 12); key_wait = 5'b00010; #1;
    check("R3 stronger non-waiting key", 5'b00010, 5'b00010);
  endtask

  task automatic t_tie();
    @(negedge clk); clear_in(); sup_en = 1'b1;
    set_d(2, 20); set_d(3, 20); key_wait = 5'b01100; #1;
    check("R4 equal strength", 5'b01000, 5'b01000);
  endtask

  task automatic t_negative();
    @(negedge clk); clear_in(); sup_en = 1'b1;
    set_d(1, -5); key_wait = 5'b00011; #1;
    check("R5 negative ties zero", 5'b00010, 5'b00000);
    @(negedge clk); clear_in();
    set_d(3, -40); set_d(4, 2); key_wait = 5'b01000; #1;
    check("R5 negative below positive", 5'b01000, 5'b00000);
    @(negedge clk); clear_in();
    set_d(0, -32768); key_wait = 5'b00011; #1;
    check("R5 most negative", 5'b00010, 5'b00000);
  endtask

  task automatic t_threshold();
    @(negedge clk); clear_in(); sup_en = 1'b1;
    set_d(0, 9); set_d(1, 6); key_wait = 5'b00010; #1;
    check("R6 delta at threshold", 5'b00010, 5'b00000);
    @(negedge clk); set_d(1, 7); #1;
    check("R6 delta above threshold", 5'b00010, 5'b00010);
  endtask

  task automatic t_release();
    @(negedge clk); clear_in(); sup_en = 1'b1;
    set_d(2, 40); set_d(4, 30); key_on = 5'b00100; key_wait = 5'b10000; #1;
    check("R9 held by active", 5'b10000, 5'b10000);
    #1; key_on = 5'b00000; set_d(2, 0); #1;
    check("R8 R9 release same cycle", 5'b00000, 5'b00000);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; sup_en = 1'b0; clear_in();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_disabled();
    t_other_active();
    t_stronger();
    t_tie();
    t_negative();
    t_threshold();
    t_release();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule